// File: doc/BRIEF.md
# Extended Control Register Write Unit

This block is the execute stage of a privileged instruction that loads a 64-bit extended control register. A request gives a register index, a high and a low 32-bit data half, the current privilege level, the operating mode, the four prefix flags and two feature-enable inputs. The block runs a layered set of legality checks. If every check passes, it commits the value to the only implemented register. If any check fails, it raises an invalid-opcode or a general-protection fault and leaves the register as it was. In both cases it produces a one-cycle done pulse.

The current register contents are always visible on a read port. Status flags are neither read nor written. Fetch, decode and exception delivery sit in neighbouring stages.

Top module: `xcr_write_unit`

## Requirements
- R1: After reset the register reads 64'h1, done is 0, the fault code is 0 (none) and the error code is 0.
- R2: done is high for exactly the cycle after a cycle in which req is high, and low after any cycle in which req is low.
- R3: A legal write stores {data_hi, data_lo} (data_hi in bits 63:32, data_lo in bits 31:0) and reports fault code 0.
- R4: Fault code 1 (invalid opcode) is reported in four cases: feat_supported is 0, os_enabled is 0, pfx_lock is 1, or any of pfx_opsize, pfx_rep, pfx_repne is 1.
- R5: Invalid-opcode conditions win over every general-protection condition.
- R6: Any index other than 0 gives fault code 2 (general protection).
- R7: In protected mode (mode 2'b10) and 64-bit mode (2'b11), a privilege level other than 0 gives fault code 2. In real-address mode (2'b00) the privilege level is ignored.
- R8: In virtual-8086 mode (2'b01) the instruction always gives fault code 2.
- R9: A value with bit 0 clear gives fault code 2, so bit 0 of the register always stays 1.
- R10: A value whose bits [2:1] equal 2'b10 gives fault code 2.
- R11: A value that sets any bit outside the implemented mask (default bits 2:0) gives fault code 2.
- R12: On any fault the register keeps its previous value, and the error code is 0 on every done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle per instruction |
| req_index | input | 32 | Register index |
| data_hi | input | 32 | Value for bits 63:32 |
| data_lo | input | 32 | Value for bits 31:0 |
| cpl | input | 2 | Current privilege level |
| mode | input | 2 | 00 real, 01 virtual-8086, 10 protected, 11 64-bit |
| pfx_lock | input | 1 | LOCK prefix present |
| pfx_opsize | input | 1 | 66h prefix present |
| pfx_rep | input | 1 | F3h prefix present |
| pfx_repne | input | 1 | F2h prefix present |
| feat_supported | input | 1 | Feature reported as supported |
| os_enabled | input | 1 | Feature enabled by the operating system |
| done | output | 1 | Result valid pulse |
| fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| err_code | output | 16 | Error code accompanying the fault |
| xcr_value | output | 64 | Current register contents |

## Verification
The assertions assume that req and all request fields are stable and known in the cycle req is high. They also assume that reset is asserted for at least one edge before the first request. The stimulus drives every input on the falling edge and holds it for a full cycle. It draws data values that are mostly confined to the implemented bits, so that legal writes happen often, and it adds occasional high-bit and reserved-bit patterns. It weights the feature, prefix and mode inputs towards legal settings, so that the general-protection checks are reached and not hidden behind invalid-opcode faults.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    MD_REAL = 2'b00,
    MD_V86  = 2'b01,
    MD_PROT = 2'b10,
    MD_LONG = 2'b11
  } mode_e;
endpackage

// File: rtl/xcr_ud_check.sv
module xcr_ud_check (
  input  logic feat_supported,
  input  logic os_enabled,
  input  logic pfx_lock,
  input  logic pfx_opsize,
  input  logic pfx_rep,
  input  logic pfx_repne,
  output logic ud_hit
);
  logic feat_off;
  logic bad_prefix;

  always_comb begin
    feat_off   = !feat_supported || !os_enabled;
    bad_prefix = pfx_lock || pfx_opsize || pfx_rep || pfx_repne;
    ud_hit     = feat_off || bad_prefix;
  end
endmodule

// File: rtl/xcr_gp_check.sv
module xcr_gp_check #(
  parameter int          IDX_W     = 32,
  parameter int          HALF_W    = 32,
  parameter logic [63:0] IMPL_MASK = 64'h7
) (
  input  logic [IDX_W-1:0]  req_index,
  input  logic [HALF_W-1:0] data_hi,
  input  logic [HALF_W-1:0] data_lo,
  input  logic [1:0]        cpl,
  input  logic [1:0]        mode,
  output logic              gp_hit
);
  import xcr_pkg::*;

  localparam int          FULL_W    = 2 * HALF_W;
  localparam logic [63:0] RESV_MASK = ~IMPL_MASK;

  logic [FULL_W-1:0] value;
  logic              mode_bad;
  logic              priv_bad;
  logic              index_bad;
  logic              resv_bad;
  logic              low_bit_bad;
  logic              pair_bad;

  always_comb begin
    value       = {data_hi, data_lo};
    mode_bad    = (mode == MD_V86);
    priv_bad    = (mode != MD_REAL) && (cpl != 2'd0);
    index_bad   = (req_index != '0);
    resv_bad    = |(value & RESV_MASK[FULL_W-1:0]);
    low_bit_bad = !value[0];
    pair_bad    = (value[2:1] == 2'b10);
    gp_hit      = mode_bad || priv_bad || index_bad ||
                  resv_bad || low_bit_bad || pair_bad;
  end
endmodule

// File: rtl/xcr_store.sv
module xcr_store #(
  parameter int          WIDTH     = 64,
  parameter logic [63:0] IMPL_MASK = 64'h7,
  parameter logic [63:0] RESET_VAL = 64'h1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)        bit_q <= RESET_VAL[i];
        else if (wr_en) bit_q <= wr_data[i];
      end
      assign q[i] = bit_q;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end

  p_low_bit_kept_r9: assert property (@(posedge clk) disable iff (rst)
    q[0] == 1'b1);
  p_pair_never_10_r10: assert property (@(posedge clk) disable iff (rst)
    q[2:1] != 2'b10);
endmodule

// File: rtl/xcr_write_unit.sv
module xcr_write_unit #(
  parameter int          IDX_W     = 32,
  parameter int          HALF_W    = 32,
  parameter int          ERR_W     = 16,
  parameter logic [63:0] IMPL_MASK = 64'h7,
  parameter logic [63:0] RESET_VAL = 64'h1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [IDX_W-1:0]    req_index,
  input  logic [HALF_W-1:0]   data_hi,
  input  logic [HALF_W-1:0]   data_lo,
  input  logic [1:0]          cpl,
  input  logic [1:0]          mode,
  input  logic                pfx_lock,
  input  logic                pfx_opsize,
  input  logic                pfx_rep,
  input  logic                pfx_repne,
  input  logic                feat_supported,
  input  logic                os_enabled,
  output logic                done,
  output logic [1:0]          fault,
  output logic [ERR_W-1:0]    err_code,
  output logic [2*HALF_W-1:0] xcr_value
);
  import xcr_pkg::*;

  localparam int          FULL_W    = 2 * HALF_W;
  localparam logic [63:0] RESV_MASK = ~IMPL_MASK;

  logic   ud_hit;
  logic   gp_hit;
  logic   commit;
  fault_e fault_d;
  logic   done_q;
  fault_e fault_q;
  logic [ERR_W-1:0] err_q;

  xcr_ud_check u_ud (
    .feat_supported (feat_supported),
    .os_enabled     (os_enabled),
    .pfx_lock       (pfx_lock),
    .pfx_opsize     (pfx_opsize),
    .pfx_rep        (pfx_rep),
    .pfx_repne      (pfx_repne),
    .ud_hit         (ud_hit)
  );

  xcr_gp_check #(
    .IDX_W     (IDX_W),
    .HALF_W    (HALF_W),
    .IMPL_MASK (IMPL_MASK)
  ) u_gp (
    .req_index (req_index),
    .data_hi   (data_hi),
    .data_lo   (data_lo),
    .cpl       (cpl),
    .mode      (mode),
    .gp_hit    (gp_hit)
  );

  always_comb begin
    if (ud_hit)      fault_d = FLT_UD;
    else if (gp_hit) fault_d = FLT_GP;
    else             fault_d = FLT_NONE;
    commit = req && (fault_d == FLT_NONE);
  end

  xcr_store #(
    .WIDTH     (FULL_W),
    .IMPL_MASK (IMPL_MASK),
    .RESET_VAL (RESET_VAL)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (commit),
    .wr_data ({data_hi, data_lo}),
    .q       (xcr_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      err_q   <= '0;
    end else begin
      done_q  <= req;
      fault_q <= req ? fault_d : FLT_NONE;
      err_q   <= '0;
    end
  end

  assign done     = done_q;
  assign fault    = fault_q;
  assign err_code = err_q;

  p_done_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> done);
  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req |=> !done);
  p_ud_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (req && ud_hit) |=> (fault == 2'd1));
  p_hold_on_fault_r12: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> (xcr_value == $past(xcr_value)));
  p_err_zero_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_code == '0));
  p_resv_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (xcr_value & RESV_MASK[FULL_W-1:0]) == '0);
endmodule

// File: tb/xcr_write_unit_bench.sv
`timescale 1ns/1ps
module xcr_write_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [31:0] req_index = '0;
  logic [31:0] data_hi = '0;
  logic [31:0] data_lo = '0;
  logic [1:0]  cpl = '0;
  logic [1:0]  mode = '0;
  logic        pfx_lock = 1'b0, pfx_opsize = 1'b0, pfx_rep = 1'b0, pfx_repne = 1'b0;
  logic        feat_supported = 1'b1, os_enabled = 1'b1;
  logic        done;
  logic [1:0]  fault;
  logic [15:0] err_code;
  logic [63:0] xcr_value;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [63:0] model_xcr = 64'h1;

  always #2 clk = ~clk;

  xcr_write_unit u_xcr_write_unit (
    .clk(clk), .rst(rst), .req(req), .req_index(req_index),
    .data_hi(data_hi), .data_lo(data_lo), .cpl(cpl), .mode(mode),
    .pfx_lock(pfx_lock), .pfx_opsize(pfx_opsize), .pfx_rep(pfx_rep),
    .pfx_repne(pfx_repne), .feat_supported(feat_supported),
    .os_enabled(os_enabled), .done(done), .fault(fault),
    .err_code(err_code), .xcr_value(xcr_value)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_fault();
    logic [63:0] v;
    v = {data_hi, data_lo};
    if (!feat_supported || !os_enabled || pfx_lock || pfx_opsize || pfx_rep || pfx_repne)
      return 2'd1;
    if (mode == 2'b01) return 2'd2;
    if (mode != 2'b00 && cpl != 2'd0) return 2'd2;
    if (req_index != 32'd0) return 2'd2;
    if ((v & ~64'h7) != 64'd0) return 2'd2;
    if (!v[0]) return 2'd2;
    if (v[2:1] == 2'b10) return 2'd2;
    return 2'd0;
  endfunction

  function automatic string ref_tag();
    logic [63:0] v;
    v = {data_hi, data_lo};
    if (!feat_supported || !os_enabled || pfx_lock || pfx_opsize || pfx_rep || pfx_repne)
      return "R4/R5";
    if (mode == 2'b01) return "R8";
    if (mode != 2'b00 && cpl != 2'd0) return "R7";
    if (req_index != 32'd0) return "R6";
    if ((v & ~64'h7) != 64'd0) return "R11";
    if (!v[0]) return "R9";
    if (v[2:1] == 2'b10) return "R10";
    return "R3";
  endfunction

  task automatic set_legal();
    req_index = 0; cpl = 0; mode = 2'b11;
    pfx_lock = 0; pfx_opsize = 0; pfx_rep = 0; pfx_repne = 0;
    feat_supported = 1; os_enabled = 1;
  endtask

  // Inputs set by the caller before this task; the request is applied for one cycle.
  task automatic issue();
    logic [1:0]  ef;
    string       tg;
    ef = ref_fault();
    tg = ref_tag();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (ef == 2'd0) model_xcr = {data_hi, data_lo};
    check({tg, " done"}, {63'd0, done}, 64'd1);                          // R2
    check({tg, " fault"}, {62'd0, fault}, {62'd0, ef});
    check({tg, " value R12"}, xcr_value, model_xcr);
    check("R12 err_code", {48'd0, err_code}, 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 value", xcr_value, 64'h1);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 fault", {62'd0, fault}, 64'd0);
    check("R1 err", {48'd0, err_code}, 64'd0);

    // R3 legal writes
    set_legal(); data_hi = 0; data_lo = 32'h7; issue();
    @(negedge clk);
    check("R2 idle done", {63'd0, done}, 64'd0);
    set_legal(); data_lo = 32'h3; issue();
    // R9 clear bit 0
    set_legal(); data_lo = 32'h6; issue();
    // R10 pair 10
    set_legal(); data_lo = 32'h5; issue();
    // R11 reserved low and high
    set_legal(); data_lo = 32'h9; issue();
    set_legal(); data_lo = 32'h1; data_hi = 32'h8000_0000; issue();
    data_hi = 0;
    // R6 nonzero index, incl. top bit
    set_legal(); data_lo = 32'h7; req_index = 32'd1; issue();
    set_legal(); data_lo = 32'h7; req_index = 32'h8000_0000; issue();
    // R7 privilege, real mode ignores it
    set_legal(); data_lo = 32'h7; cpl = 2'd3; mode = 2'b10; issue();
    set_legal(); data_lo = 32'h1; cpl = 2'd3; mode = 2'b00; issue();
    // R8 virtual-8086
    set_legal(); data_lo = 32'h7; mode = 2'b01; issue();
    // R4 each invalid-opcode cause, R5 priority over GP
    set_legal(); data_lo = 32'h7; feat_supported = 0; issue();
    set_legal(); data_lo = 32'h7; os_enabled = 0; issue();
    set_legal(); data_lo = 32'h7; pfx_lock = 1; issue();
    set_legal(); data_lo = 32'h7; pfx_opsize = 1; issue();
    set_legal(); data_lo = 32'h7; pfx_rep = 1; issue();
    set_legal(); data_lo = 32'h7; pfx_repne = 1; issue();
    set_legal(); data_lo = 32'h0; req_index = 5; mode = 2'b01; pfx_lock = 1; issue();
    // back-to-back requests (R2)
    set_legal(); data_lo = 32'h7; req = 1'b1;
    @(negedge clk);
    data_lo = 32'h3;
    @(negedge clk);
    req = 1'b0;
    check("R2 back-to-back done", {63'd0, done}, 64'd1);
    check("R3 back-to-back value", xcr_value, 64'h3);
    model_xcr = 64'h3;

    // constrained random
    for (int n = 0; n < 600; n++) begin
      set_legal();
      data_lo = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h7);
      data_hi = ($urandom % 8 == 0) ? $urandom : 32'd0;
      req_index = ($urandom % 8 == 0) ? $urandom : 32'd0;
      cpl = ($urandom % 6 == 0) ? 2'($urandom) : 2'd0;
      mode = 2'($urandom);
      if (mode == 2'b01 && ($urandom % 2 == 0)) mode = 2'b10;
      feat_supported = ($urandom % 16 != 0);
      os_enabled = ($urandom % 16 != 0);
      pfx_lock = ($urandom % 20 == 0);
      pfx_opsize = ($urandom % 20 == 0);
      pfx_rep = ($urandom % 20 == 0);
      pfx_repne = ($urandom % 20 == 0);
      issue();
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        check("R2 idle", {63'd0, done}, 64'd0);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule